// File: doc/BRIEF.md
# Reorder Buffer with In-Order Retirement

This block keeps the program order of instructions that an out-of-order core has issued. Each issued instruction takes one slot of a small circular buffer and receives that slot's index as its tag. Results come back out of order over a result bus, carrying the tag. The block marks the matching slot complete. It also answers operand lookups by tag, so that issue logic can pick up a value that is finished but not yet retired.

Instructions leave strictly from the oldest slot, at most one per cycle. Each slot has one of four kinds, and the kind decides what retirement does:
- An ordinary instruction writes its value to the architectural register file.
- A store holds the retirement port for two cycles while it writes memory.
- A branch resolved as taken empties the buffer and sends a restart address to fetch. It also raises a flush line that the other speculative queues obey.
- A halt marker reports that the program has finished.

Top module: `retire_buffer`

## Requirements
- R1: After reset the buffer is empty. allocReady is 1, allocTag is 0, and regWe, memWrite, memFinish, flush and haltRetired are all 0.
- R2: Each accepted allocation receives the tag of the next slot in rotation, counting 0 to 5 and then wrapping to 0. When 6 slots are occupied, allocReady is 0 until a retirement frees a slot.
- R3: A result-bus write with cdbValid[p] set to a live tag marks that slot complete. Every port p writes in the same cycle, and two ports may write different slots together. From the next cycle, lookupReady is 1 and lookupValue is the written value. A slot that has not been written reports lookupReady 0.
- R4: Only the oldest slot can retire. A younger complete slot waits behind an incomplete older one. At most one retirement happens per cycle, so ready slots leave on consecutive cycles in allocation order.
- R5: Kind 0 (ordinary) retires in the first cycle in which it is oldest and complete. In that cycle regWe is 1, with regAddr set to its destination and regData set to its value.
- R6: Kind 1 (store) retires over exactly two cycles, with memWrite high in both. memAddr and memData carry the address and data from the result bus. memFinish is high only in the second cycle, when memory takes the write. Nothing else retires during these two cycles.
- R7: Kind 2 (branch) with cdbTaken 1 raises flush for one cycle, with redirectPc set to the target carried on cdbAddr. On the next cycle every slot is empty, allocReady is 1 and allocTag is 0.
- R8: Kind 2 with cdbTaken 0 retires in one cycle. It raises no flush and writes no register.
- R9: Kind 3 (halt) is complete as soon as it is allocated. It raises haltRetired for the one cycle in which it retires.
- R10: An allocation request made in the flush cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rstN | input | 1 | active-low synchronous reset |
| allocValid | input | 1 | request to allocate a slot |
| allocKind | input | 2 | 0 ordinary, 1 store, 2 branch, 3 halt |
| allocDest | input | 5 | destination register for ordinary instructions |
| allocReady | output | 1 | a slot is free |
| allocTag | output | 3 | tag given to the requested slot |
| cdbValid | input | 2 | one write strobe per result port |
| cdbTag | input | 6 | tag for each port, 3 bits each |
| cdbValue | input | 64 | result or store data, 32 bits each |
| cdbAddr | input | 64 | store address or branch target, 32 bits each |
| cdbTaken | input | 2 | branch outcome for each port |
| lookupTag | input | 3 | tag to inspect |
| lookupReady | output | 1 | inspected slot is live and complete |
| lookupValue | output | 32 | value of the inspected slot |
| regWe | output | 1 | register write on retirement |
| regAddr | output | 5 | register written |
| regData | output | 32 | value written |
| memWrite | output | 1 | store write in progress |
| memFinish | output | 1 | second cycle of a store write |
| memAddr | output | 32 | store address |
| memData | output | 32 | store data |
| flush | output | 1 | taken branch retiring; clear speculative state |
| redirectPc | output | 32 | fetch restart address |
| haltRetired | output | 1 | halt marker retiring |

## Verification
Faults in the head or tail pointers would show up as wrong tags on the very next allocation. They would also cause retirements out of the expected order. The bench therefore rotates the ring through every starting offset and checks each retirement cycle by cycle. A bad completion bit would surface either as a retirement that comes too early, while an older slot is still pending, or as a lookup that disagrees with the value that was written. A store sequencer in the wrong state would change the length of the memWrite window, and the bench compares that length cycle by cycle. A flush that leaves stale state behind would appear in the cycle right after it, as a nonzero allocTag or a live lookup.

// File: rtl/rob_pkg.sv
package rob_pkg;

  typedef enum logic [1:0] {
    KIND_REG    = 2'd0,
    KIND_STORE  = 2'd1,
    KIND_BRANCH = 2'd2,
    KIND_HALT   = 2'd3
  } robKind_e;

  // strobes from control to the slot storage
  typedef struct packed {
    logic alloc;
    logic pop;
    logic flush;
  } robStrobes_t;

endpackage

// File: rtl/rob_slots.sv
module rob_slots
  import rob_pkg::*;
#(
  parameter int DEPTH  = 6,
  parameter int TAG_W  = 3,
  parameter int DATA_W = 32,
  parameter int REG_W  = 5,
  parameter int NCDB   = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  robStrobes_t           strobes,
  input  logic [TAG_W-1:0]      tailTag,
  input  logic [TAG_W-1:0]      headTag,
  input  robKind_e              allocKind,
  input  logic [REG_W-1:0]      allocDest,
  input  logic [NCDB-1:0]       cdbValid,
  input  logic [NCDB*TAG_W-1:0] cdbTag,
  input  logic [NCDB*DATA_W-1:0] cdbValue,
  input  logic [NCDB*DATA_W-1:0] cdbAddr,
  input  logic [NCDB-1:0]       cdbTaken,
  input  logic [TAG_W-1:0]      lookupTag,
  output logic                  lookupReady,
  output logic [DATA_W-1:0]     lookupValue,
  output logic                  headValid,
  output logic                  headReady,
  output robKind_e              headKind,
  output logic [REG_W-1:0]      headDest,
  output logic [DATA_W-1:0]     headValue,
  output logic [DATA_W-1:0]     headAddr,
  output logic                  headTaken
);

  logic              validQ [DEPTH];
  logic              readyQ [DEPTH];
  robKind_e          kindQ  [DEPTH];
  logic [REG_W-1:0]  destQ  [DEPTH];
  logic [DATA_W-1:0] valueQ [DEPTH];
  logic [DATA_W-1:0] addrQ  [DEPTH];
  logic              takenQ [DEPTH];

  always_ff @(posedge clk) begin
    for (int e = 0; e < DEPTH; e++) begin
      if (!rstN || strobes.flush) begin
        validQ[e] <= 1'b0;
        readyQ[e] <= 1'b0;
      end else begin
        for (int p = 0; p < NCDB; p++) begin
          if (cdbValid[p] && validQ[e] && cdbTag[p*TAG_W +: TAG_W] == TAG_W'(e)) begin
            readyQ[e] <= 1'b1;
            valueQ[e] <= cdbValue[p*DATA_W +: DATA_W];
            addrQ[e]  <= cdbAddr[p*DATA_W +: DATA_W];
            takenQ[e] <= cdbTaken[p];
          end
        end
        if (strobes.alloc && tailTag == TAG_W'(e)) begin
          validQ[e] <= 1'b1;
          readyQ[e] <= (allocKind == KIND_HALT);
          kindQ[e]  <= allocKind;
          destQ[e]  <= allocDest;
          takenQ[e] <= 1'b0;
        end
        if (strobes.pop && headTag == TAG_W'(e)) begin
          validQ[e] <= 1'b0;
          readyQ[e] <= 1'b0;
        end
      end
    end
  end

  assign headValid   = validQ[headTag];
  assign headReady   = readyQ[headTag];
  assign headKind    = kindQ[headTag];
  assign headDest    = destQ[headTag];
  assign headValue   = valueQ[headTag];
  assign headAddr    = addrQ[headTag];
  assign headTaken   = takenQ[headTag];
  assign lookupReady = validQ[lookupTag] && readyQ[lookupTag];
  assign lookupValue = valueQ[lookupTag];

  // an allocation never lands on a slot still in use
  assert_alloc_free_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.alloc |-> !validQ[tailTag]);

  // a retiring slot was live and complete
  assert_pop_complete_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.pop |-> (validQ[headTag] && readyQ[headTag]));

endmodule

// File: rtl/rob_ctrl.sv
module rob_ctrl
  import rob_pkg::*;
#(
  parameter int DEPTH = 6,
  parameter int TAG_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             allocValid,
  input  logic             headValid,
  input  logic             headReady,
  input  robKind_e         headKind,
  input  logic             headTaken,
  output robStrobes_t      strobes,
  output logic [TAG_W-1:0] headTag,
  output logic [TAG_W-1:0] tailTag,
  output logic             allocReady,
  output logic             regWe,
  output logic             memWrite,
  output logic             memFinish,
  output logic             flush,
  output logic             haltRetired
);

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL   = CNT_W'(DEPTH);
  localparam logic [TAG_W-1:0] LAST   = TAG_W'(DEPTH - 1);

  typedef enum logic {ST_IDLE, ST_STORE2} retState_e;

  retState_e        state;
  logic [CNT_W-1:0] count;
  logic             headLive, idle, storeFirst, branchQuiet, doAlloc, doPop;

  function automatic logic [TAG_W-1:0] bump(input logic [TAG_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign idle        = (state == ST_IDLE);
  assign headLive    = headValid && headReady;
  assign storeFirst  = idle && headLive && headKind == KIND_STORE;
  assign regWe       = idle && headLive && headKind == KIND_REG;
  assign flush       = idle && headLive && headKind == KIND_BRANCH && headTaken;
  assign branchQuiet = idle && headLive && headKind == KIND_BRANCH && !headTaken;
  assign haltRetired = idle && headLive && headKind == KIND_HALT;
  assign memFinish   = (state == ST_STORE2);
  assign memWrite    = storeFirst || memFinish;
  assign allocReady  = (count != FULL);
  assign doAlloc     = allocValid && allocReady && !flush;
  assign doPop       = regWe || memFinish || branchQuiet || haltRetired;

  assign strobes.alloc = doAlloc;
  assign strobes.pop   = doPop;
  assign strobes.flush = flush;

  always_ff @(posedge clk) begin
    if (!rstN || flush) begin
      headTag <= '0;
      tailTag <= '0;
      count   <= '0;
      state   <= ST_IDLE;
    end else begin
      if (doPop)   headTag <= bump(headTag);
      if (doAlloc) tailTag <= bump(tailTag);
      count <= count + CNT_W'(doAlloc) - CNT_W'(doPop);
      state <= storeFirst ? ST_STORE2 : ST_IDLE;
    end
  end

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULL);

  assert_one_retire_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({regWe, memFinish, branchQuiet, flush, haltRetired}));

  assert_store_second_R6: assert property (@(posedge clk) disable iff (!rstN)
    storeFirst |=> (memFinish && memWrite));

  assert_store_origin_R6: assert property (@(posedge clk) disable iff (!rstN)
    memFinish |-> $past(storeFirst));

  assert_flush_empty_R7: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (count == '0 && !headValid));

endmodule

// File: rtl/retire_buffer.sv
module retire_buffer
  import rob_pkg::*;
#(
  parameter int DEPTH  = 6,
  parameter int DATA_W = 32,
  parameter int REG_W  = 5,
  parameter int NCDB   = 2,
  localparam int TAG_W = $clog2(DEPTH)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   allocValid,
  input  logic [1:0]             allocKind,
  input  logic [REG_W-1:0]       allocDest,
  output logic                   allocReady,
  output logic [TAG_W-1:0]       allocTag,
  input  logic [NCDB-1:0]        cdbValid,
  input  logic [NCDB*TAG_W-1:0]  cdbTag,
  input  logic [NCDB*DATA_W-1:0] cdbValue,
  input  logic [NCDB*DATA_W-1:0] cdbAddr,
  input  logic [NCDB-1:0]        cdbTaken,
  input  logic [TAG_W-1:0]       lookupTag,
  output logic                   lookupReady,
  output logic [DATA_W-1:0]      lookupValue,
  output logic                   regWe,
  output logic [REG_W-1:0]       regAddr,
  output logic [DATA_W-1:0]      regData,
  output logic                   memWrite,
  output logic                   memFinish,
  output logic [DATA_W-1:0]      memAddr,
  output logic [DATA_W-1:0]      memData,
  output logic                   flush,
  output logic [DATA_W-1:0]      redirectPc,
  output logic                   haltRetired
);

  robStrobes_t       strobes;
  logic [TAG_W-1:0]  headTag, tailTag;
  logic              headValid, headReady, headTaken;
  robKind_e          headKind;
  logic [REG_W-1:0]  headDest;
  logic [DATA_W-1:0] headValue, headAddr;

  rob_ctrl #(.DEPTH(DEPTH), .TAG_W(TAG_W)) ctrl (
    .clk(clk), .rstN(rstN), .allocValid(allocValid),
    .headValid(headValid), .headReady(headReady), .headKind(headKind),
    .headTaken(headTaken), .strobes(strobes), .headTag(headTag),
    .tailTag(tailTag), .allocReady(allocReady), .regWe(regWe),
    .memWrite(memWrite), .memFinish(memFinish), .flush(flush),
    .haltRetired(haltRetired)
  );

  rob_slots #(.DEPTH(DEPTH), .TAG_W(TAG_W), .DATA_W(DATA_W),
              .REG_W(REG_W), .NCDB(NCDB)) slots (
    .clk(clk), .rstN(rstN), .strobes(strobes), .tailTag(tailTag),
    .headTag(headTag), .allocKind(robKind_e'(allocKind)),
    .allocDest(allocDest), .cdbValid(cdbValid), .cdbTag(cdbTag),
    .cdbValue(cdbValue), .cdbAddr(cdbAddr), .cdbTaken(cdbTaken),
    .lookupTag(lookupTag), .lookupReady(lookupReady),
    .lookupValue(lookupValue), .headValid(headValid),
    .headReady(headReady), .headKind(headKind), .headDest(headDest),
    .headValue(headValue), .headAddr(headAddr), .headTaken(headTaken)
  );

  assign allocTag   = tailTag;
  assign regAddr    = headDest;
  assign regData    = headValue;
  assign memAddr    = headAddr;
  assign memData    = headValue;
  assign redirectPc = headAddr;

  // nothing leaves the buffer while reset is held
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rstN |=> !(regWe || memWrite || flush || haltRetired));

endmodule

// File: tb/retire_buffer_test.sv
`timescale 1ns/1ps
module retire_buffer_test;

  logic        clk = 1'b0;
  logic        rstN;
  logic        allocValid;
  logic [1:0]  allocKind;
  logic [4:0]  allocDest;
  logic        allocReady;
  logic [2:0]  allocTag;
  logic [1:0]  cdbValid;
  logic [5:0]  cdbTag;
  logic [63:0] cdbValue, cdbAddr;
  logic [1:0]  cdbTaken;
  logic [2:0]  lookupTag;
  logic        lookupReady;
  logic [31:0] lookupValue;
  logic        regWe;
  logic [4:0]  regAddr;
  logic [31:0] regData;
  logic        memWrite, memFinish;
  logic [31:0] memAddr, memData;
  logic        flush;
  logic [31:0] redirectPc;
  logic        haltRetired;

  int numChecks = 0;
  int numFails  = 0;
  bit finished  = 0;
  int expTail   = 0;

  always #2 clk = ~clk;

  retire_buffer uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    numChecks++;
    if (act !== exp) begin
      numFails++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic doAlloc(input logic [1:0] kind, input logic [4:0] dest, output logic [2:0] tag);
    allocValid = 1'b1; allocKind = kind; allocDest = dest;
    #0.2 tag = allocTag;
    tick();
    allocValid = 1'b0;
  endtask

  task automatic doCdb(input logic [2:0] tag, input logic [31:0] val,
                       input logic [31:0] addr, input logic taken);
    cdbValid = 2'b01; cdbTag = {3'd0, tag}; cdbValue = {32'd0, val};
    cdbAddr = {32'd0, addr}; cdbTaken = {1'b0, taken};
    tick();
    cdbValid = 2'b00;
  endtask

  task automatic doCdb2(input logic [2:0] tagA, input logic [31:0] valA,
                        input logic [2:0] tagB, input logic [31:0] valB);
    cdbValid = 2'b11; cdbTag = {tagB, tagA}; cdbValue = {valB, valA};
    cdbAddr = '0; cdbTaken = 2'b00;
    tick();
    cdbValid = 2'b00;
  endtask

  task automatic look(input logic [2:0] tag);
    lookupTag = tag; #0.2;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", numChecks, numFails);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      numFails++;
      $display("FAIL watchdog actual running expected done");
      summary();
      $finish;
    end
  end

  initial begin
    logic [2:0]  tg, ts, tr, tb, tx;
    logic [2:0]  tags [6];
    logic [4:0]  dests [6];
    logic [31:0] vals [6];

    rstN = 1'b0; allocValid = 1'b0; allocKind = '0; allocDest = '0;
    cdbValid = '0; cdbTag = '0; cdbValue = '0; cdbAddr = '0; cdbTaken = '0;
    lookupTag = '0;
    repeat (3) tick();
    rstN = 1'b1;
    #0.2;
    chk("R1 allocReady", allocReady, 1);
    chk("R1 allocTag", allocTag, 0);
    chk("R1 quiet", {regWe, memWrite, memFinish, flush, haltRetired}, 0);

    // rotate the ring through every starting offset
    for (int off = 0; off < 6; off++) begin
      doAlloc(2'd0, 5'd1, tg);
      chk("R2 rotate tag", tg, expTail);
      doCdb(tg, 32'h55 + off, 32'd0, 1'b0);
      chk("R5 single regWe", regWe, 1);
      chk("R5 single data", regData, 32'h55 + off);
      tick();
      expTail = (expTail + 1) % 6;

      for (int i = 0; i < 6; i++) begin
        dests[i] = 5'((off * 6 + i) % 31 + 1);
        vals[i]  = 32'h1000 * off + i + 7;
        doAlloc(2'd0, dests[i], tg);
        tags[i] = tg;
        chk("R2 sequential tag", tg, (expTail + i) % 6);
      end
      chk("R2 full stall", allocReady, 0);

      doCdb2(tags[5], vals[5], tags[4], vals[4]);
      chk("R4 younger waits", regWe, 0);
      look(tags[4]);
      chk("R3 lookup ready", lookupReady, 1);
      chk("R3 lookup value", lookupValue, vals[4]);
      look(tags[5]);
      chk("R3 dual port value", lookupValue, vals[5]);
      for (int i = 3; i >= 1; i--) begin
        doCdb(tags[i], vals[i], 32'd0, 1'b0);
        chk("R4 blocked by oldest", regWe, 0);
      end
      look(tags[0]);
      chk("R3 unwritten not ready", lookupReady, 0);
      doCdb(tags[0], vals[0], 32'd0, 1'b0);
      for (int i = 0; i < 6; i++) begin
        if (i > 0) tick();
        chk("R4 order regWe", regWe, 1);
        chk("R5 regAddr", regAddr, dests[i]);
        chk("R5 regData", regData, vals[i]);
      end
      tick();
      chk("R4 drained", regWe, 0);
      chk("R2 space again", allocReady, 1);
    end

    // store holding the retirement port for two cycles
    doAlloc(2'd1, 5'd0, ts);
    doAlloc(2'd0, 5'd7, tr);
    doCdb(tr, 32'hABCD, 32'd0, 1'b0);
    chk("R4 behind store", regWe, 0);
    doCdb(ts, 32'hDA7A, 32'h2C0, 1'b0);
    chk("R6 first memWrite", memWrite, 1);
    chk("R6 first no finish", memFinish, 0);
    chk("R6 memAddr", memAddr, 32'h2C0);
    chk("R6 memData", memData, 32'hDA7A);
    chk("R6 first blocks", regWe, 0);
    tick();
    chk("R6 second memWrite", memWrite, 1);
    chk("R6 second finish", memFinish, 1);
    chk("R6 second blocks", regWe, 0);
    tick();
    chk("R6 write over", memWrite, 0);
    chk("R5 after store", regWe, 1);
    chk("R5 after store addr", regAddr, 7);
    tick();
    expTail = (expTail + 2) % 6;

    // branch that was not taken
    doAlloc(2'd2, 5'd0, tb);
    doCdb(tb, 32'd0, 32'h400, 1'b0);
    chk("R8 no flush", flush, 0);
    chk("R8 no regWe", regWe, 0);
    tick();
    expTail = (expTail + 1) % 6;
    doAlloc(2'd0, 5'd2, tg);
    chk("R8 slot freed", tg, expTail);
    doCdb(tg, 32'h9, 32'd0, 1'b0);
    tick();
    expTail = (expTail + 1) % 6;

    // taken branch with an allocation request in the flush cycle
    doAlloc(2'd2, 5'd0, tb);
    doAlloc(2'd0, 5'd9, tx);
    doCdb(tx, 32'h77, 32'd0, 1'b0);
    chk("R4 behind branch", regWe, 0);
    cdbValid = 2'b01; cdbTag = {3'd0, tb}; cdbValue = '0;
    cdbAddr = {32'd0, 32'h250}; cdbTaken = 2'b01;
    tick();
    cdbValid = 2'b00;
    chk("R7 flush", flush, 1);
    chk("R7 redirectPc", redirectPc, 32'h250);
    chk("R7 no regWe", regWe, 0);
    allocValid = 1'b1; allocKind = 2'd0; allocDest = 5'd3;
    tick();
    allocValid = 1'b0;
    chk("R10 alloc dropped", allocTag, 0);
    chk("R7 flush over", flush, 0);
    chk("R7 allocReady", allocReady, 1);
    look(tx);
    chk("R7 slot cleared", lookupReady, 0);
    chk("R7 nothing retires", regWe, 0);

    // halt marker
    doAlloc(2'd3, 5'd0, tg);
    chk("R9 halt retires", haltRetired, 1);
    chk("R9 no regWe", regWe, 0);
    tick();
    chk("R9 pulse ends", haltRetired, 0);
    chk("R9 slot freed", allocTag, 1);

    finished = 1;
    summary();
    $finish;
  end

endmodule